// File: doc/BRIEF.md
# Precision-Time Event Packet Classifier

This block sits behind a header parser on the receive path. It decides, one packet at a time, whether the packet is a precision-time event message whose arrival should be timestamped. The parser presents the fields it has extracted with a single-cycle valid strobe: EtherType, IP protocol, UDP source and destination ports, and the message-type byte. One clock later the block answers with a single-cycle capture request. A downstream capture unit uses that request to latch the current time.

Software picks one of four capture modes:

- **Off:** no packet is ever stamped.
- **Version-1:** only UDP event traffic is considered, and only the single message kind chosen by a separate select bit counts.
- **Version-2:** every event message counts, whether it was carried directly over Ethernet or inside UDP.
- **All:** every packet is stamped.

An optional source-port check narrows the UDP path. A global capture enable suppresses all requests. Configuration inputs are sampled in the same cycle as the header strobe.

Top module: `ptp_event_classifier`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `captureReq` is 0.
- R2: `captureReq` is high only in the cycle that directly follows a cycle with `hdrValid` high. Each strobe yields a pulse of at most one cycle, and no pulse appears without a strobe.
- R3: When `captureEn` is 0 in the strobe cycle, no pulse is produced, whatever the fields and mode.
- R4: Mode 0 (`captureMode` = 2'b00, off) never produces a pulse.
- R5: Mode 3 (`captureMode` = 2'b11, all) produces a pulse for every strobe while enabled, whatever the field values.
- R6: The Ethernet path hits when `etherType` equals 16'h88F7. This path is considered only in mode 2.
- R7: The UDP path hits when `ipProto` equals 17 and `udpDstPort` equals 319.
- R8: When `srcPortCheck` is 1, the UDP path additionally requires `udpSrcPort` equal to 319. When it is 0, the source port is ignored.
- R9: Mode 1 (`captureMode` = 2'b01, version-1) pulses only on a UDP-path hit whose message type (the low nibble of `msgTypeByte`) is 0 (Sync) when `v1DelayReqSel` = 0, or 1 (Delay_Req) when `v1DelayReqSel` = 1. An Ethernet-path hit alone does not count.
- R10: Mode 2 (`captureMode` = 2'b10, version-2) pulses on an Ethernet-path or UDP-path hit whose message type is 0 to 3. The upper nibble of `msgTypeByte` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hdrValid | input | 1 | Header fields valid strobe, one cycle per packet |
| etherType | input | 16 | Parsed EtherType |
| ipProto | input | 8 | Parsed IP protocol number |
| udpSrcPort | input | 16 | Parsed UDP source port |
| udpDstPort | input | 16 | Parsed UDP destination port |
| msgTypeByte | input | 8 | First byte of the time-sync message; the low nibble is the type |
| captureEn | input | 1 | Global capture enable |
| captureMode | input | 2 | 0 off, 1 version-1, 2 version-2, 3 all |
| v1DelayReqSel | input | 1 | Version-1 kind: 0 Sync, 1 Delay_Req |
| srcPortCheck | input | 1 | Also require UDP source port 319 |
| captureReq | output | 1 | Capture request pulse, one cycle after the strobe |

## Verification
The assertions check on every cycle that:

- a pulse is always preceded by a strobe;
- a disabled or off configuration never pulses;
- the all mode always pulses;
- version-1 mode never pulses on non-UDP or wrong-port traffic;
- version-2 mode never pulses on a message type above 3.

Only the bench's sweeps can show the full decision table. They cover every combination of mode, enable, message select and source-port check, crossed with hit and miss values on each header field and both nibble halves of the type byte. Only these sweeps confirm that each mode pulses exactly where it should, not merely that it stays silent where it must.

// File: rtl/ptp_cls_pkg.sv
package ptp_cls_pkg;

  typedef enum logic [1:0] {
    CAP_OFF = 2'd0,
    CAP_V1  = 2'd1,
    CAP_V2  = 2'd2,
    CAP_ALL = 2'd3
  } capMode_e;

  // Strobes issued by the control decode to the datapath compare logic
  typedef struct packed {
    logic evalV1;       // judge this packet as a version-1 candidate
    logic evalV2;       // judge this packet as a version-2 candidate
    logic evalAll;      // request unconditionally
    logic v1DelayReq;   // version-1 kind: 1 = Delay_Req, 0 = Sync
    logic srcCheck;     // require source port on the UDP path
  } clsStrobe_t;

endpackage

// File: rtl/ptp_cls_control.sv
module ptp_cls_control
  import ptp_cls_pkg::*;
(
  input  logic       hdrValid,
  input  logic       captureEn,
  input  logic [1:0] captureMode,
  input  logic       v1DelayReqSel,
  input  logic       srcPortCheck,
  output clsStrobe_t strobe
);

  capMode_e modeSel;
  logic     armed;

  always_comb begin
    modeSel = capMode_e'(captureMode);
    armed   = hdrValid & captureEn;
  end

  always_comb begin
    strobe            = '0;
    strobe.v1DelayReq = v1DelayReqSel;
    strobe.srcCheck   = srcPortCheck;
    unique case (modeSel)
      CAP_OFF: ;
      CAP_V1:  strobe.evalV1  = armed;
      CAP_V2:  strobe.evalV2  = armed;
      CAP_ALL: strobe.evalAll = armed;
      default: ;
    endcase
  end

endmodule

// File: rtl/ptp_cls_datapath.sv
module ptp_cls_datapath
  import ptp_cls_pkg::*;
#(
  parameter int ETYPE_W      = 16,
  parameter int PROTO_W      = 8,
  parameter int PORT_W       = 16,
  parameter int MSGB_W       = 8,
  parameter int MSG_W        = 4,
  parameter int EVENT_ETYPE  = 16'h88F7,
  parameter int UDP_PROTO    = 17,
  parameter int EVENT_PORT   = 319,
  parameter int V1_SYNC      = 0,
  parameter int V1_DREQ      = 1,
  parameter int V2_LAST_EVT  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  clsStrobe_t         strobe,
  input  logic [ETYPE_W-1:0] etherType,
  input  logic [PROTO_W-1:0] ipProto,
  input  logic [PORT_W-1:0]  udpSrcPort,
  input  logic [PORT_W-1:0]  udpDstPort,
  input  logic [MSGB_W-1:0]  msgTypeByte,
  output logic               captureReq
);

  localparam logic [ETYPE_W-1:0] ETYPE_C  = ETYPE_W'(EVENT_ETYPE);
  localparam logic [PROTO_W-1:0] PROTO_C  = PROTO_W'(UDP_PROTO);
  localparam logic [PORT_W-1:0]  PORT_C   = PORT_W'(EVENT_PORT);
  localparam logic [MSG_W-1:0]   SYNC_C   = MSG_W'(V1_SYNC);
  localparam logic [MSG_W-1:0]   DREQ_C   = MSG_W'(V1_DREQ);
  localparam logic [MSG_W-1:0]   V2LAST_C = MSG_W'(V2_LAST_EVT);

  logic             l2Hit;
  logic             l4Base;
  logic             srcOk;
  logic             l4Hit;
  logic [MSG_W-1:0] msgType;
  logic [MSG_W-1:0] v1Want;
  logic             v1Hit;
  logic             v2Hit;
  logic             reqNext;

  // Field comparators
  always_comb begin
    l2Hit   = (etherType == ETYPE_C);
    l4Base  = (ipProto == PROTO_C) && (udpDstPort == PORT_C);
    srcOk   = !strobe.srcCheck || (udpSrcPort == PORT_C);
    l4Hit   = l4Base && srcOk;
    msgType = msgTypeByte[MSG_W-1:0];
  end

  // Per-mode match terms
  always_comb begin
    v1Want  = strobe.v1DelayReq ? DREQ_C : SYNC_C;
    v1Hit   = strobe.evalV1 && l4Hit && (msgType == v1Want);
    v2Hit   = strobe.evalV2 && (l2Hit || l4Hit) && (msgType <= V2LAST_C);
    reqNext = v1Hit || v2Hit || strobe.evalAll;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) captureReq <= 1'b0;
    else       captureReq <= reqNext;
  end

endmodule

// File: rtl/ptp_event_classifier.sv
module ptp_event_classifier
  import ptp_cls_pkg::*;
#(
  parameter int ETYPE_W = 16,
  parameter int PROTO_W = 8,
  parameter int PORT_W  = 16,
  parameter int MSGB_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hdrValid,
  input  logic [ETYPE_W-1:0] etherType,
  input  logic [PROTO_W-1:0] ipProto,
  input  logic [PORT_W-1:0]  udpSrcPort,
  input  logic [PORT_W-1:0]  udpDstPort,
  input  logic [MSGB_W-1:0]  msgTypeByte,
  input  logic               captureEn,
  input  logic [1:0]         captureMode,
  input  logic               v1DelayReqSel,
  input  logic               srcPortCheck,
  output logic               captureReq
);

  clsStrobe_t strobe;

  ptp_cls_control u_ctrl (
    .hdrValid      (hdrValid),
    .captureEn     (captureEn),
    .captureMode   (captureMode),
    .v1DelayReqSel (v1DelayReqSel),
    .srcPortCheck  (srcPortCheck),
    .strobe        (strobe)
  );

  ptp_cls_datapath #(
    .ETYPE_W (ETYPE_W),
    .PROTO_W (PROTO_W),
    .PORT_W  (PORT_W),
    .MSGB_W  (MSGB_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .etherType   (etherType),
    .ipProto     (ipProto),
    .udpSrcPort  (udpSrcPort),
    .udpDstPort  (udpDstPort),
    .msgTypeByte (msgTypeByte),
    .captureReq  (captureReq)
  );

endmodule

// File: rtl/ptp_cls_checker.sv
module ptp_cls_checker #(
  parameter int PROTO_W = 8,
  parameter int PORT_W  = 16,
  parameter int MSGB_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              hdrValid,
  input logic              captureEn,
  input logic [1:0]        captureMode,
  input logic [PROTO_W-1:0] ipProto,
  input logic [PORT_W-1:0] udpDstPort,
  input logic [MSGB_W-1:0] msgTypeByte,
  input logic              captureReq
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> !captureReq);

  p_pulse_needs_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    captureReq |-> $past(hdrValid));

  p_enable_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && !captureEn) |=> !captureReq);

  p_off_mode_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && captureMode == 2'd0) |=> !captureReq);

  p_all_mode_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && captureEn && captureMode == 2'd3) |=> captureReq);

  p_v1_udp_only_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && captureMode == 2'd1 &&
     (ipProto != PROTO_W'(17) || udpDstPort != PORT_W'(319))) |=> !captureReq);

  p_v2_type_limit_r10: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && captureMode == 2'd2 && msgTypeByte[3:0] > 4'd3) |=> !captureReq);

endmodule

bind ptp_event_classifier ptp_cls_checker #(
  .PROTO_W (PROTO_W),
  .PORT_W  (PORT_W),
  .MSGB_W  (MSGB_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .hdrValid    (hdrValid),
  .captureEn   (captureEn),
  .captureMode (captureMode),
  .ipProto     (ipProto),
  .udpDstPort  (udpDstPort),
  .msgTypeByte (msgTypeByte),
  .captureReq  (captureReq)
);

// File: tb/tb_ptp_event_classifier.sv
`timescale 1ns/1ps
module tb_ptp_event_classifier;

  logic        clk = 1'b0;
  logic        rstN;
  logic        hdrValid;
  logic [15:0] etherType;
  logic [7:0]  ipProto;
  logic [15:0] udpSrcPort;
  logic [15:0] udpDstPort;
  logic [7:0]  msgTypeByte;
  logic        captureEn;
  logic [1:0]  captureMode;
  logic        v1DelayReqSel;
  logic        srcPortCheck;
  logic        captureReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  ptp_event_classifier dut (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .etherType(etherType),
    .ipProto(ipProto), .udpSrcPort(udpSrcPort), .udpDstPort(udpDstPort),
    .msgTypeByte(msgTypeByte), .captureEn(captureEn), .captureMode(captureMode),
    .v1DelayReqSel(v1DelayReqSel), .srcPortCheck(srcPortCheck),
    .captureReq(captureReq)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: captureReq=%0b expected %0b (mode=%0d en=%0b sel=%0b sc=%0b et=%h pr=%0d sp=%0d dp=%0d mt=%h)",
               req, act, exp, captureMode, captureEn, v1DelayReqSel, srcPortCheck,
               etherType, ipProto, udpSrcPort, udpDstPort, msgTypeByte);
    end
  endtask

  // Reference model built from the requirement text
  function automatic logic expect_req(output string tag);
    logic l2, l4base, l4, srcOk;
    logic [3:0] mt;
    l2     = (etherType == 16'h88F7);                  // R6
    l4base = (ipProto == 8'd17) && (udpDstPort == 16'd319); // R7
    srcOk  = !srcPortCheck || (udpSrcPort == 16'd319);      // R8
    l4     = l4base && srcOk;
    mt     = msgTypeByte[3:0];
    if (!captureEn) begin tag = "R3"; return 1'b0; end
    case (captureMode)
      2'd0: begin tag = "R4"; return 1'b0; end
      2'd3: begin tag = "R5"; return 1'b1; end
      2'd1: begin
        if (l4base && !srcOk) tag = "R8";
        else if (!l4base)     tag = "R7";
        else                  tag = "R9";
        return l4 && (mt == (v1DelayReqSel ? 4'd1 : 4'd0));
      end
      default: begin
        if (mt > 4'd3)             tag = "R10";
        else if (l2)               tag = "R6";
        else if (l4base && !srcOk) tag = "R8";
        else                       tag = "R7";
        return (l2 || l4) && (mt <= 4'd3);
      end
    endcase
  endfunction

  task automatic send_and_check();
    string tag;
    logic  exp;
    hdrValid = 1'b1;
    exp = expect_req(tag);
    @(negedge clk);
    check(captureReq, exp, tag);
    hdrValid = 1'b0;
    @(negedge clk);
    check(captureReq, 1'b0, "R2");  // single-cycle pulse, nothing without strobe
  endtask

  initial begin
    rstN = 1'b0; hdrValid = 1'b1; etherType = 16'h88F7; ipProto = 8'd17;
    udpSrcPort = 16'd319; udpDstPort = 16'd319; msgTypeByte = 8'h00;
    captureEn = 1'b1; captureMode = 2'd3; v1DelayReqSel = 1'b0; srcPortCheck = 1'b0;
    repeat (3) @(negedge clk);
    check(captureReq, 1'b0, "R1");  // held quiet in reset despite all-mode strobe
    hdrValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check(captureReq, 1'b0, "R1");

    for (int m = 0; m < 4; m++)
      for (int en = 0; en < 2; en++)
        for (int sel = 0; sel < 2; sel++)
          for (int sc = 0; sc < 2; sc++)
            for (int e = 0; e < 2; e++)
              for (int p = 0; p < 2; p++)
                for (int d = 0; d < 2; d++)
                  for (int s = 0; s < 2; s++)
                    for (int t = 0; t < 6; t++)
                      for (int u = 0; u < 2; u++) begin
                        captureMode   = 2'(m);
                        captureEn     = en[0];
                        v1DelayReqSel = sel[0];
                        srcPortCheck  = sc[0];
                        etherType     = e[0] ? 16'h88F7 : 16'h0800;
                        ipProto       = p[0] ? 8'd17 : 8'd6;
                        udpDstPort    = d[0] ? 16'd319 : 16'd320;
                        udpSrcPort    = s[0] ? 16'd319 : 16'd1234;
                        msgTypeByte   = {(u[0] ? 4'hA : 4'h0), 4'(t)};
                        send_and_check();
                      end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule